// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block is the digital side of a two-channel telephony codec's time-division multiplexed serial bus. Both voice channels share one serial output and one serial input. Each channel has its own transmit strobe and its own receive strobe, so the two directions, and the two channels, are timed independently. A strobe marks the start of an 8-bit companded sample, sent or received most significant bit first. Samples reach and leave the block through parallel per-channel registers. The transmit side uses a valid/ready handshake and the receive side uses a one-cycle valid pulse.

The block runs on the serial bit clock (2.048 MHz or 4.096 MHz). Outgoing bits change on the rising edge and incoming bits are sampled on the falling edge. A static mode input picks one of two framings. In nondelayed framing, the first bit belongs to the cycle in which the strobe is first seen high. In delayed framing, it comes one bit clock later. A second static input picks the companding law. The law only decides the idle code sent when a channel has nothing loaded. A channel whose strobes stop for a programmable number of frames powers down. A new strobe on that channel wakes it.

Top module: `pcm_dual_port`

## Requirements
- R1: While reset is held, `dx_oe`, `rx_valid`, `tx_collide` and `pwr_down` are all 0 and every `tx_ready` bit is 1.
- R2: With `late_mode`=0, a transmit strobe first sampled high at rising edge k starts a slot. Bit 7 of the sample is on `dx` in the cycle after edge k, and bits 6 down to 0 follow one per cycle. `dx_oe` is high for exactly those 8 cycles and low outside slots.
- R3: With `late_mode`=1, every transmit and receive slot starts one bit clock later than in R2 and R4, and `dx_oe` stays low in the cycle after edge k.
- R4: With `late_mode`=0, a receive strobe first sampled high at edge k means bit 7 is taken from `dr` at the falling edge inside the cycle after edge k. The following bits come one per cycle. The assembled byte appears on `rx_data` with `rx_valid` high for one cycle, in the cycle after edge k+8.
- R5: `tx_ready` of a channel is 1 when its holding register is empty and the channel is not powered down. A byte accepted on `tx_valid`&&`tx_ready` is the one sent at that channel's next slot, and `tx_ready` returns to 1 once the slot has taken it.
- R6: A slot on a channel with an empty holding register sends 0xFF when `alaw_sel`=0 and 0xD5 when `alaw_sel`=1.
- R7: When both transmit slots start in the same cycle, channel 0's sample is sent. Channel 1 keeps its loaded sample for its next slot. `tx_collide` is high for one cycle, in the first bit cycle of that slot.
- R8: With `pd_frames`=N>0, a channel goes into powerdown (`pwr_down` bit 1) in the cycle after edge k+N·FRAME_BITS, where edge k was the last one sampling a rising edge on either of its strobes. With `pd_frames`=0 no channel is powered down.
- R9: While a channel is powered down, its `tx_ready` is 0, its loaded sample is discarded and `dr` produces no byte. A strobe rise wakes it at that edge, and that slot is served normally.
- R10: A transmit slot on one channel and a receive slot on the other can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| late_mode | input | 1 | 1: delayed framing, 0: nondelayed framing |
| alaw_sel | input | 1 | 1: A-law idle code, 0: µ-law idle code |
| pd_frames | input | PD_W | Silent frames before powerdown, 0 disables it |
| fsx | input | NUM_CH | Per-channel transmit frame strobes |
| fsr | input | NUM_CH | Per-channel receive frame strobes |
| dr | input | 1 | Serial receive data |
| tx_data | input | NUM_CH×8 | Per-channel transmit samples |
| tx_valid | input | NUM_CH | Per-channel transmit sample valid |
| tx_ready | output | NUM_CH | Per-channel holding register can take a sample |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx` (low models high impedance) |
| rx_data | output | NUM_CH×8 | Per-channel received samples |
| rx_valid | output | NUM_CH | One-cycle pulse when a received byte is presented |
| tx_collide | output | 1 | Pulse when two transmit slots started together |
| pwr_down | output | NUM_CH | Per-channel powerdown state |

## Verification
The assertions take for granted that strobes rise on a free bus: a transmit strobe never arrives while another slot still holds `dx`. They also assume that `late_mode`, `alaw_sel` and `pd_frames` change only between slots, and that FRAME_BITS is larger than a slot. The bench keeps to this by running each frame, directed or random, to its end plus one idle cycle before the next strobe. It changes the mode inputs only in those gaps. It makes the only simultaneous transmit strobes the deliberate collision case, and it overlaps transmit on one channel only with receive on the other.

// File: rtl/pcm_port_pkg.sv
// Package: shared sample type, width and idle codes for the PCM serial port.
// Assumes 8-bit companded samples, the same for both laws.
package pcm_port_pkg;
    localparam int SAMPLE_W = 8;
    typedef logic [SAMPLE_W-1:0] sample_t;

    localparam sample_t IDLE_MULAW = 8'hFF;
    localparam sample_t IDLE_ALAW  = 8'hD5;

    // Idle code for the selected companding law
    function automatic sample_t idle_code(input logic alaw);
        return alaw ? IDLE_ALAW : IDLE_MULAW;
    endfunction
endpackage

// File: rtl/pcm_tx_hold.sv
// Per-channel transmit holding register with a valid/ready handshake.
// It offers the loaded sample, or the idle code when empty, to the serializer,
// and empties when the serializer takes it. Powerdown flushes it and holds
// ready low. Assumes take is a single-cycle pulse.
module pcm_tx_hold
    import pcm_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    alaw_sel,
    input  logic    pwr_down,
    input  sample_t in_data,
    input  logic    in_valid,
    output logic    in_ready,
    input  logic    take,
    output sample_t sample_out
);
    logic    full;
    sample_t held;

    assign in_ready   = !full && !pwr_down;
    assign sample_out = full ? held : idle_code(alaw_sel);

    // Load on handshake, empty on take, flush in powerdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (pwr_down) begin
            full <= 1'b0;
        end else begin
            if (take) full <= 1'b0;
            if (in_valid && in_ready) begin
                full <= 1'b1;
                held <= in_data;
            end
        end
    end
endmodule

// File: rtl/pcm_tx_serial.sv
// Shared transmit serializer. It starts an 8-cycle slot on a start pulse,
// giving the lowest-numbered channel priority, and shifts MSB first.
// It flags a collision when several starts arrive together on a free bus.
// Assumes starts only arrive while the bus is free; one arriving mid-slot is ignored.
module pcm_tx_serial
    import pcm_port_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      start,
    input  sample_t [NUM_CH-1:0]   samples,
    output logic [NUM_CH-1:0]      take,
    output logic                   dx,
    output logic                   dx_oe,
    output logic                   collide
);
    localparam int LEFT_W = $clog2(SAMPLE_W);

    logic [NUM_CH-1:0]   grant;
    logic                any_start;
    logic                multi;
    sample_t             chosen;
    logic [SAMPLE_W-2:0] shreg;
    logic [LEFT_W-1:0]   left;

    // Lowest-index priority pick among the start requests
    always_comb begin
        grant     = '0;
        any_start = 1'b0;
        multi     = 1'b0;
        chosen    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (start[i]) begin
                if (any_start) begin
                    multi = 1'b1;
                end else begin
                    grant[i]  = 1'b1;
                    any_start = 1'b1;
                    chosen    = samples[i];
                end
            end
        end
    end

    assign take = dx_oe ? '0 : grant;

    // Slot sequencer: load, shift seven more bits, then release the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dx      <= 1'b0;
            dx_oe   <= 1'b0;
            shreg   <= '0;
            left    <= '0;
            collide <= 1'b0;
        end else begin
            collide <= 1'b0;
            if (!dx_oe) begin
                if (any_start) begin
                    dx      <= chosen[SAMPLE_W-1];
                    shreg   <= chosen[SAMPLE_W-2:0];
                    left    <= LEFT_W'(SAMPLE_W - 1);
                    dx_oe   <= 1'b1;
                    collide <= multi;
                end
            end else if (left == '0) begin
                dx_oe <= 1'b0;
                dx    <= 1'b0;
            end else begin
                dx    <= shreg[SAMPLE_W-2];
                shreg <= {shreg[SAMPLE_W-3:0], 1'b0};
                left  <= left - LEFT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcm_rx_deser.sv
// Per-channel receive deserializer. After a start pulse it shifts in 8 bits,
// one per cycle, from the falling-edge sample of the data pin. It then presents
// the byte with a one-cycle valid pulse. Powerdown cancels an unfinished byte.
// Assumes the falling-edge sample is already retimed into this clock's domain.
module pcm_rx_deser
    import pcm_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    pwr_down,
    input  logic    dr_s,
    output sample_t data,
    output logic    valid
);
    localparam int CNT_W = $clog2(SAMPLE_W) + 1;

    logic [CNT_W-1:0]    cnt;
    logic [SAMPLE_W-2:0] shreg;

    // Bit counter, shift register and byte presentation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                cnt <= CNT_W'(SAMPLE_W);
            end else if (pwr_down) begin
                cnt <= '0;
            end else if (cnt != '0) begin
                shreg <= {shreg[SAMPLE_W-3:0], dr_s};
                cnt   <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    valid <= 1'b1;
                    data  <= {shreg, dr_s};
                end
            end
        end
    end
endmodule

// File: rtl/pcm_pd_monitor.sv
// Per-channel inactivity monitor. It counts bit clocks since the channel's last
// strobe rise and enters powerdown after pd_frames whole frames of silence.
// Any strobe rise wakes the channel. Assumes FRAME_BITS exceeds one slot.
module pcm_pd_monitor #(
    parameter int FRAME_BITS = 256,
    parameter int PD_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            activity,
    input  logic [PD_W-1:0] pd_frames,
    output logic            pwr_down
);
    localparam int CNT_W = PD_W + $clog2(FRAME_BITS) + 1;

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(pd_frames) * CNT_W'(FRAME_BITS);

    // Silence counter and powerdown state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            pwr_down <= 1'b0;
        end else if (activity || pd_frames == '0) begin
            idle_cnt <= '0;
            pwr_down <= 1'b0;
        end else if (!pwr_down) begin
            idle_cnt <= idle_cnt + CNT_W'(1);
            if (idle_cnt + CNT_W'(1) == limit) pwr_down <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_dual_port.sv
// Top of the multi-channel PCM serial port. It detects strobe rises, applies
// delayed or nondelayed framing and retimes the receive pin on the falling
// edge. It also wires the per-channel holding registers, deserializers and
// powerdown monitors to the shared serializer.
// Assumes the mode inputs are static while any slot is in progress.
module pcm_dual_port
    import pcm_port_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int FRAME_BITS = 256,
    parameter int PD_W       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         late_mode,
    input  logic                         alaw_sel,
    input  logic [PD_W-1:0]              pd_frames,
    input  logic [NUM_CH-1:0]            fsx,
    input  logic [NUM_CH-1:0]            fsr,
    input  logic                         dr,
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0] tx_data,
    input  logic [NUM_CH-1:0]            tx_valid,
    output logic [NUM_CH-1:0]            tx_ready,
    output logic                         dx,
    output logic                         dx_oe,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0] rx_data,
    output logic [NUM_CH-1:0]            rx_valid,
    output logic                         tx_collide,
    output logic [NUM_CH-1:0]            pwr_down
);
    logic [NUM_CH-1:0] fsx_q, fsr_q;
    logic [NUM_CH-1:0] rise_x, rise_r;
    logic [NUM_CH-1:0] rise_x_d, rise_r_d;
    logic [NUM_CH-1:0] start_x, start_r;
    logic [NUM_CH-1:0] take;
    sample_t [NUM_CH-1:0] tx_sample;
    logic              dr_s;

    assign rise_x  = fsx & ~fsx_q;
    assign rise_r  = fsr & ~fsr_q;
    assign start_x = late_mode ? rise_x_d : rise_x;
    assign start_r = late_mode ? rise_r_d : rise_r;

    // Strobe history for rise detection and the one-clock framing delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsx_q    <= '0;
            fsr_q    <= '0;
            rise_x_d <= '0;
            rise_r_d <= '0;
        end else begin
            fsx_q    <= fsx;
            fsr_q    <= fsr;
            rise_x_d <= rise_x;
            rise_r_d <= rise_r;
        end
    end

    // Receive pin sampled on the falling bit-clock edge
    always_ff @(negedge clk) begin
        if (!rst_n) dr_s <= 1'b0;
        else        dr_s <= dr;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pcm_tx_hold u_hold (
            .clk        (clk),
            .rst_n      (rst_n),
            .alaw_sel   (alaw_sel),
            .pwr_down   (pwr_down[c]),
            .in_data    (tx_data[c]),
            .in_valid   (tx_valid[c]),
            .in_ready   (tx_ready[c]),
            .take       (take[c]),
            .sample_out (tx_sample[c])
        );

        pcm_rx_deser u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start_r[c]),
            .pwr_down (pwr_down[c]),
            .dr_s     (dr_s),
            .data     (rx_data[c]),
            .valid    (rx_valid[c])
        );

        pcm_pd_monitor #(
            .FRAME_BITS (FRAME_BITS),
            .PD_W       (PD_W)
        ) u_pd (
            .clk       (clk),
            .rst_n     (rst_n),
            .activity  (rise_x[c] | rise_r[c]),
            .pd_frames (pd_frames),
            .pwr_down  (pwr_down[c])
        );
    end

    pcm_tx_serial #(
        .NUM_CH (NUM_CH)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_x),
        .samples (tx_sample),
        .take    (take),
        .dx      (dx),
        .dx_oe   (dx_oe),
        .collide (tx_collide)
    );
endmodule

// File: rtl/pcm_dual_port_chk.sv
// Checker for the PCM serial port, bound to the top module. It watches slot
// length, the receive pulse width, collision timing and the powerdown handshake.
// Assumes transmit strobes rise only on a free bus.
module pcm_dual_port_chk #(
    parameter int NUM_CH = 2,
    parameter int PD_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PD_W-1:0]   pd_frames,
    input logic              dx_oe,
    input logic              tx_collide,
    input logic [NUM_CH-1:0] tx_ready,
    input logic [NUM_CH-1:0] rx_valid,
    input logic [NUM_CH-1:0] pwr_down
);
    logic [3:0] oe_run;

    // Length of the current run of driven cycles
    always_ff @(posedge clk) begin
        if (!rst_n)     oe_run <= '0;
        else if (dx_oe) oe_run <= oe_run + 4'd1;
        else            oe_run <= '0;
    end

    assert_slot_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> (oe_run < 4'd8));

    assert_slot_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dx_oe && oe_run != 4'd0) |-> (oe_run == 4'd8));

    assert_collide_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_collide |-> dx_oe);

    assert_collide_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_collide |=> !tx_collide);

    assert_pd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_frames) == '0) |-> (pwr_down == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[c] |=> !rx_valid[c]);

        assert_pd_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_down[c] |-> !tx_ready[c]);

        assert_pd_no_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_down[c] && $past(pwr_down[c])) |-> !rx_valid[c]);
    end
endmodule

bind pcm_dual_port pcm_dual_port_chk #(
    .NUM_CH (NUM_CH),
    .PD_W   (PD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_frames  (pd_frames),
    .dx_oe      (dx_oe),
    .tx_collide (tx_collide),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .pwr_down   (pwr_down)
);

// File: tb/test_pcm_dual_port.sv
module test_pcm_dual_port;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 256;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            late_mode, alaw_sel;
    logic [7:0]      pd_frames;
    logic [1:0]      fsx, fsr;
    logic            dr;
    logic [1:0][7:0] tx_data;
    logic [1:0]      tx_valid, tx_ready;
    logic            dx, dx_oe;
    logic [1:0][7:0] rx_data;
    logic [1:0]      rx_valid;
    logic            tx_collide;
    logic [1:0]      pwr_down;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_dual_port i_pcm_dual_port (
        .clk(clk), .rst_n(rst_n), .late_mode(late_mode), .alaw_sel(alaw_sel),
        .pd_frames(pd_frames), .fsx(fsx), .fsr(fsr), .dr(dr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .dx(dx), .dx_oe(dx_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_collide(tx_collide), .pwr_down(pwr_down)
    );

    function automatic logic [7:0] idle_of(input logic alaw);
        return alaw ? 8'hD5 : 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_tx(input int ch, input logic [7:0] b);
        chk(tx_ready[ch] == 1'b1, "R5 ready before load", tx_ready[ch], 1);
        tx_data[ch]  = b;
        tx_valid[ch] = 1'b1;
        tick();
        tx_valid[ch] = 1'b0;
        chk(tx_ready[ch] == 1'b0, "R5 ready after load", tx_ready[ch], 0);
    endtask

    // Strobe the channels in mask and collect the 8 bits sent on dx
    task automatic tx_slot(input logic [1:0] mask, input logic [7:0] exp, input string req);
        logic [7:0] got = '0;
        bit         oe_ok = 1'b1;
        fsx = mask;
        tick();
        fsx = '0;
        if (late_mode) begin
            @(negedge clk);
            chk(dx_oe == 1'b0, "R3 no drive in strobe cycle", dx_oe, 0);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!dx_oe) oe_ok = 1'b0;
            got = {got[6:0], dx};
            if (i == 0)
                chk(tx_collide == (mask == 2'b11), "R7 collide flag", tx_collide, mask == 2'b11);
        end
        chk(oe_ok, "R2 oe high over slot", oe_ok, 1);
        chk(got == exp, req, got, exp);
        @(negedge clk);
        chk(dx_oe == 1'b0 && tx_collide == 1'b0, "R2 bus released after slot", dx_oe, 0);
    endtask

    // Strobe a receive slot and drive the byte on dr MSB first
    task automatic rx_slot(input int ch, input logic [7:0] b, input string req);
        fsr[ch] = 1'b1;
        tick();
        fsr[ch] = 1'b0;
        if (late_mode) tick();
        for (int i = 7; i >= 0; i--) begin
            dr = b[i];
            tick();
        end
        @(negedge clk);
        chk(rx_valid[ch] == 1'b1, {req, " valid"}, rx_valid[ch], 1);
        chk(rx_data[ch] == b, req, rx_data[ch], b);
        @(negedge clk);
        chk(rx_valid[ch] == 1'b0, "R4 valid single cycle", rx_valid[ch], 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7));
        rst_n = 1'b0; late_mode = 1'b0; alaw_sel = 1'b0; pd_frames = '0;
        fsx = '0; fsr = '0; dr = 1'b0; tx_data = '0; tx_valid = '0;
        repeat (4) tick();
        // R1 reset state
        chk(dx_oe == 0 && rx_valid == 0 && tx_collide == 0 && pwr_down == 0,
            "R1 outputs idle in reset", {dx_oe, rx_valid, tx_collide, pwr_down}, 0);
        chk(tx_ready == 2'b11, "R1 ready in reset", tx_ready, 3);
        rst_n = 1'b1;
        tick();

        // R2 nondelayed transmit of a loaded byte, R5 handshake
        load_tx(0, 8'hA5);
        tx_slot(2'b01, 8'hA5, "R2 nondelayed byte");
        chk(tx_ready[0] == 1'b1, "R5 ready back after slot", tx_ready[0], 1);

        // R6 idle codes for both laws
        tx_slot(2'b10, 8'hFF, "R6 mu-law idle");
        alaw_sel = 1'b1;
        tick();
        tx_slot(2'b10, 8'hD5, "R6 A-law idle");
        alaw_sel = 1'b0;

        // R4 nondelayed receive on both channels
        rx_slot(0, 8'h3C, "R4 rx ch0");
        rx_slot(1, 8'hC3, "R4 rx ch1");

        // R3 delayed framing for both directions
        late_mode = 1'b1;
        tick();
        load_tx(1, 8'h5A);
        tx_slot(2'b10, 8'h5A, "R3 delayed tx");
        rx_slot(0, 8'h96, "R3 delayed rx");
        late_mode = 1'b0;
        tick();

        // R7 collision: channel 0 wins, channel 1 keeps its byte
        load_tx(0, 8'h11);
        load_tx(1, 8'h22);
        tx_slot(2'b11, 8'h11, "R7 winner byte");
        chk(tx_ready[1] == 1'b0, "R7 loser keeps sample", tx_ready[1], 0);
        tx_slot(2'b10, 8'h22, "R7 loser sent later");

        // R8/R9 powerdown after one frame of silence
        pd_frames = 8'd1;
        tx_slot(2'b01, 8'hFF, "R2 slot before powerdown");
        load_tx(0, 8'h77);
        repeat (247) @(negedge clk);
        chk(pwr_down[0] == 1'b0, "R8 awake before limit", pwr_down[0], 0);
        @(negedge clk);
        chk(pwr_down[0] == 1'b1, "R8 down at limit", pwr_down[0], 1);
        chk(tx_ready[0] == 1'b0, "R9 not ready when down", tx_ready[0], 0);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk);
                #1;
                dr = i[0];
                @(negedge clk);
                if (rx_valid != 0) seen = 1'b1;
            end
            chk(!seen, "R9 dr ignored when down", seen, 0);
        end
        tick();
        tx_slot(2'b01, 8'hFF, "R9 flushed sample gives idle");
        chk(pwr_down[0] == 1'b0, "R9 woken by strobe", pwr_down[0], 0);
        pd_frames = '0;
        repeat (600) tick();
        chk(pwr_down == 2'b00, "R8 disabled when zero", pwr_down, 0);

        // R10 random concurrent frames: transmit on one channel, receive on the other
        for (int n = 0; n < 40; n++) begin
            int         a     = $urandom_range(0, 1);
            bit         have  = $urandom_range(0, 1);
            logic [7:0] tb    = 8'($urandom);
            logic [7:0] rb    = 8'($urandom);
            logic [7:0] exp;
            late_mode = 1'($urandom_range(0, 1));
            alaw_sel  = 1'($urandom_range(0, 1));
            tick();
            if (have) load_tx(a, tb);
            exp = have ? tb : idle_of(alaw_sel);
            fork
                tx_slot(2'b01 << a, exp, "R10 concurrent tx");
                rx_slot(1 - a, rb, "R10 concurrent rx");
            join
        end

        finish_run();
    end
endmodule